// File: doc/BRIEF.md
# Register Rename Status Table

This block holds an architectural register file in which every register carries a producer tag. The tag names the execution station that will next write the register. A tag of zero means no write is pending and the stored value is current. Issue logic uses the block in two ways. It looks up the two source registers of an instruction, and each lookup returns either a ready value or the tag to wait for. It also renames the instruction's destination register by recording the tag of the station that was just allocated.

Results come back on a broadcast bus as a tag and a value. A register takes a broadcast value only if its recorded tag equals the broadcast tag, and its tag then returns to zero. A later rename of the same register therefore replaces the earlier producer, and that earlier producer's result never lands in the register. This removes write-after-write and write-after-read hazards without any extra storage.

Lookups are combinational and see a broadcast that arrives in the same cycle. Renames and writebacks take effect at the next clock edge.

Top module: `rename_status_table`

## Requirements
- R1: A synchronous active-high reset clears every producer tag and every stored value to zero, so every lookup then returns ready=1, tag 0 and value 0.
- R2: A rename (ren_valid=1 with a nonzero ren_tag) records ren_tag as the producer of register ren_idx from the next cycle on. A lookup of that register then returns ready=0 and tag=ren_tag.
- R3: A broadcast (bc_valid=1 with a nonzero bc_tag) writes bc_value into every register whose producer tag equals bc_tag and clears that tag to zero at the next edge. Registers with any other tag keep their contents.
- R4: A lookup of a register whose tag is zero returns ready=1, tag 0 and the stored value. A lookup of a register with a pending tag, and no matching broadcast, returns ready=0, that tag, and a value field of zero.
- R5: After a register is renamed twice, a broadcast of the older tag leaves the register pending on the newer tag with its value unchanged. Only the newer tag's broadcast writes it.
- R6: A lookup in the same cycle as a broadcast whose tag matches the looked-up register's tag returns ready=1, tag 0 and the broadcast value.
- R7: If a rename of a register and a broadcast of that register's current tag fall in the same cycle, the register afterwards holds the new tag and its old value. The broadcast value is not written.
- R8: Tag 0 names no producer. A rename with ren_valid=0 or ren_tag=0 changes nothing, and a broadcast with bc_valid=0 or bc_tag=0 changes nothing.
- R9: A lookup of a register that is being renamed in the same cycle returns the register's state from before that rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a_idx | input | IDX_W (4) | First source register index |
| src_a_ready | output | 1 | First source value is available |
| src_a_tag | output | TAG_W (3) | Producer tag of first source, 0 when ready |
| src_a_value | output | DATA_W (32) | First source value, 0 when pending |
| src_b_idx | input | IDX_W (4) | Second source register index |
| src_b_ready | output | 1 | Second source value is available |
| src_b_tag | output | TAG_W (3) | Producer tag of second source, 0 when ready |
| src_b_value | output | DATA_W (32) | Second source value, 0 when pending |
| ren_valid | input | 1 | Destination rename request |
| ren_idx | input | IDX_W (4) | Destination register index |
| ren_tag | input | TAG_W (3) | Tag of the issuing station |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W (3) | Tag of the producing station |
| bc_value | input | DATA_W (32) | Broadcast result value |

## Verification
Two pairs of functions can land on the same register in one cycle. The first pair is a broadcast and a source lookup. The bench provokes it by holding a lookup on a pending register while it drives the matching tag onto the bus, and it requires the broadcast value to appear at once with tag zero. The second pair is a rename and a broadcast of the old tag. The bench drives both in one cycle and then judges the register's later lookups: the new tag must still be pending, and the old result must never appear, even after the new tag's own broadcast arrives.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
    parameter int RRT_NUM_REGS = 16;
    parameter int RRT_DATA_W   = 32;
    parameter int RRT_TAG_W    = 3;
    localparam int RRT_IDX_W   = $clog2(RRT_NUM_REGS);

    typedef logic [RRT_TAG_W-1:0]  tag_t;
    typedef logic [RRT_DATA_W-1:0] data_t;
    typedef logic [RRT_IDX_W-1:0]  idx_t;

    localparam tag_t NO_PRODUCER = '0;

    typedef struct packed {
        tag_t  tag;
        data_t value;
    } reg_entry_t;

    typedef struct packed {
        logic  ready;
        tag_t  tag;
        data_t value;
    } src_view_t;

    function automatic logic tag_live(input logic vld, input tag_t t);
        return vld && (t != NO_PRODUCER);
    endfunction
endpackage

// File: rtl/rrt_entry.sv
module rrt_entry
    import rrt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ren_sel,
    input  tag_t       ren_tag,
    input  logic       bc_live,
    input  tag_t       bc_tag,
    input  data_t      bc_value,
    output reg_entry_t entry
);
    logic bc_hit;
    assign bc_hit = bc_live && (entry.tag == bc_tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            entry.tag   <= NO_PRODUCER;
            entry.value <= '0;
        end else if (ren_sel) begin
            // a fresh producer wins over a result for the one it replaces
            entry.tag <= ren_tag;
        end else if (bc_hit) begin
            entry.tag   <= NO_PRODUCER;
            entry.value <= bc_value;
        end
    end
endmodule

// File: rtl/rrt_lookup.sv
module rrt_lookup
    import rrt_pkg::*;
#(
    parameter int NUM_REGS = RRT_NUM_REGS
) (
    input  idx_t                      idx,
    input  reg_entry_t [NUM_REGS-1:0] table_q,
    input  logic                      bc_live,
    input  tag_t                      bc_tag,
    input  data_t                     bc_value,
    output src_view_t                 view
);
    reg_entry_t sel;

    always_comb begin
        sel = table_q[idx];
        if (sel.tag == NO_PRODUCER) begin
            view.ready = 1'b1;
            view.tag   = NO_PRODUCER;
            view.value = sel.value;
        end else if (bc_live && (sel.tag == bc_tag)) begin
            view.ready = 1'b1;
            view.tag   = NO_PRODUCER;
            view.value = bc_value;
        end else begin
            view.ready = 1'b0;
            view.tag   = sel.tag;
            view.value = '0;
        end
    end
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
    import rrt_pkg::*;
#(
    parameter int NUM_REGS = RRT_NUM_REGS,
    parameter int IDX_W    = RRT_IDX_W,
    parameter int TAG_W    = RRT_TAG_W,
    parameter int DATA_W   = RRT_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  src_a_idx,
    output logic              src_a_ready,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic [DATA_W-1:0] src_a_value,
    input  logic [IDX_W-1:0]  src_b_idx,
    output logic              src_b_ready,
    output logic [TAG_W-1:0]  src_b_tag,
    output logic [DATA_W-1:0] src_b_value,
    input  logic              ren_valid,
    input  logic [IDX_W-1:0]  ren_idx,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value
);
    localparam int NUM_SRC = 2;

    reg_entry_t [NUM_REGS-1:0] ent;
    logic                      ren_live;
    logic                      bc_live;
    idx_t      [NUM_SRC-1:0]   src_idx;
    src_view_t [NUM_SRC-1:0]   src_view;

    assign ren_live = tag_live(ren_valid, ren_tag);
    assign bc_live  = tag_live(bc_valid, bc_tag);

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        rrt_entry u_entry (
            .clk      (clk),
            .rst      (rst),
            .ren_sel  (ren_live && (ren_idx == IDX_W'(gi))),
            .ren_tag  (ren_tag),
            .bc_live  (bc_live),
            .bc_tag   (bc_tag),
            .bc_value (bc_value),
            .entry    (ent[gi])
        );
    end

    assign src_idx[0] = src_a_idx;
    assign src_idx[1] = src_b_idx;

    for (genvar gs = 0; gs < NUM_SRC; gs++) begin : g_src
        rrt_lookup #(.NUM_REGS(NUM_REGS)) u_lookup (
            .idx      (src_idx[gs]),
            .table_q  (ent),
            .bc_live  (bc_live),
            .bc_tag   (bc_tag),
            .bc_value (bc_value),
            .view     (src_view[gs])
        );
    end

    assign src_a_ready = src_view[0].ready;
    assign src_a_tag   = src_view[0].tag;
    assign src_a_value = src_view[0].value;
    assign src_b_ready = src_view[1].ready;
    assign src_b_tag   = src_view[1].tag;
    assign src_b_value = src_view[1].value;
endmodule

// File: rtl/rrt_checker.sv
module rrt_checker
    import rrt_pkg::*;
#(
    parameter int NUM_REGS = RRT_NUM_REGS
) (
    input logic                      clk,
    input logic                      rst,
    input reg_entry_t [NUM_REGS-1:0] ent,
    input idx_t                      src_a_idx,
    input logic                      src_a_ready,
    input tag_t                      src_a_tag,
    input data_t                     src_a_value,
    input idx_t                      src_b_idx,
    input logic                      ren_valid,
    input idx_t                      ren_idx,
    input tag_t                      ren_tag,
    input logic                      bc_valid,
    input tag_t                      bc_tag,
    input data_t                     bc_value
);
    logic any_tag;
    always_comb begin
        any_tag = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) any_tag = any_tag | (ent[i].tag != NO_PRODUCER);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !any_tag); // R1

    AST_RENAME_RECORDED: assert property (@(posedge clk) disable iff (rst)
        (ren_valid && ren_tag != NO_PRODUCER) |=> ent[$past(ren_idx)].tag == $past(ren_tag)); // R2

    AST_WRITEBACK_A: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && bc_tag != NO_PRODUCER && ent[src_a_idx].tag == bc_tag
         && !(ren_valid && ren_tag != NO_PRODUCER && ren_idx == src_a_idx))
        |=> ent[$past(src_a_idx)].tag == NO_PRODUCER
            && ent[$past(src_a_idx)].value == $past(bc_value)); // R3

    AST_PENDING_FORMAT: assert property (@(posedge clk) disable iff (rst)
        !src_a_ready |-> (src_a_tag != NO_PRODUCER && src_a_value == '0)); // R4

    AST_READY_NO_TAG: assert property (@(posedge clk) disable iff (rst)
        src_a_ready |-> src_a_tag == NO_PRODUCER); // R4

    AST_UNTOUCHED_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!(bc_valid && bc_tag != NO_PRODUCER && ent[src_b_idx].tag == bc_tag)
         && !(ren_valid && ren_tag != NO_PRODUCER && ren_idx == src_b_idx))
        |=> ent[$past(src_b_idx)] == $past(ent[src_b_idx])); // R8

    AST_BYPASS_A: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && bc_tag != NO_PRODUCER && ent[src_a_idx].tag == bc_tag)
        |-> (src_a_ready && src_a_value == bc_value)); // R6

    AST_COLLISION_NEW_TAG: assert property (@(posedge clk) disable iff (rst)
        (ren_valid && ren_tag != NO_PRODUCER && bc_valid && bc_tag != NO_PRODUCER
         && ent[ren_idx].tag == bc_tag)
        |=> ent[$past(ren_idx)].value == $past(ent[ren_idx].value)); // R7
endmodule

bind rename_status_table rrt_checker #(.NUM_REGS(NUM_REGS)) u_rrt_checker (
    .clk         (clk),
    .rst         (rst),
    .ent         (ent),
    .src_a_idx   (src_a_idx),
    .src_a_ready (src_a_ready),
    .src_a_tag   (src_a_tag),
    .src_a_value (src_a_value),
    .src_b_idx   (src_b_idx),
    .ren_valid   (ren_valid),
    .ren_idx     (ren_idx),
    .ren_tag     (ren_tag),
    .bc_valid    (bc_valid),
    .bc_tag      (bc_tag),
    .bc_value    (bc_value)
);

// File: tb/rename_status_table_bench.sv
module rename_status_table_bench;
    import rrt_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    idx_t  src_a_idx = '0, src_b_idx = '0, ren_idx = '0;
    logic  src_a_ready, src_b_ready;
    tag_t  src_a_tag, src_b_tag;
    data_t src_a_value, src_b_value;
    logic  ren_valid = 1'b0, bc_valid = 1'b0;
    tag_t  ren_tag = '0, bc_tag = '0;
    data_t bc_value = '0;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    rename_status_table u_rename_status_table (
        .clk, .rst,
        .src_a_idx, .src_a_ready, .src_a_tag, .src_a_value,
        .src_b_idx, .src_b_ready, .src_b_tag, .src_b_value,
        .ren_valid, .ren_idx, .ren_tag,
        .bc_valid, .bc_tag, .bc_value
    );

    task automatic idle();
        ren_valid = 1'b0; ren_tag = '0; ren_idx = '0;
        bc_valid = 1'b0; bc_tag = '0; bc_value = '0;
    endtask

    // apply current inputs across one rising edge, return just after the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic look_a(input idx_t r, input logic er, input tag_t et, input data_t ev, input string req);
        src_a_idx = r;
        #1;
        checks++;
        if (src_a_ready !== er || src_a_tag !== et || src_a_value !== ev) begin
            failures++;
            $display("FAIL %s reg=%0d actual ready=%0b tag=%0d value=%h expected ready=%0b tag=%0d value=%h",
                     req, r, src_a_ready, src_a_tag, src_a_value, er, et, ev);
        end
    endtask

    task automatic look_b(input idx_t r, input logic er, input tag_t et, input data_t ev, input string req);
        src_b_idx = r;
        #1;
        checks++;
        if (src_b_ready !== er || src_b_tag !== et || src_b_value !== ev) begin
            failures++;
            $display("FAIL %s reg=%0d actual ready=%0b tag=%0d value=%h expected ready=%0b tag=%0d value=%h",
                     req, r, src_b_ready, src_b_tag, src_b_value, er, et, ev);
        end
    endtask

    task automatic rename(input idx_t r, input tag_t t);
        ren_valid = 1'b1; ren_idx = r; ren_tag = t;
        tick();
    endtask

    task automatic bcast(input tag_t t, input data_t v);
        bc_valid = 1'b1; bc_tag = t; bc_value = v;
        tick();
    endtask

    task automatic t_reset();
        for (int r = 0; r < RRT_NUM_REGS; r += 5) begin
            look_a(idx_t'(r), 1'b1, '0, '0, "R1");
            look_b(idx_t'(r), 1'b1, '0, '0, "R1");
        end
    endtask

    task automatic t_rename_and_write();
        rename(4'd3, 3'd5);
        look_a(4'd3, 1'b0, 3'd5, '0, "R2");
        look_b(4'd3, 1'b0, 3'd5, '0, "R4");
        rename(4'd6, 3'd4);
        rename(4'd7, 3'd4);
        bcast(3'd5, 32'h0000_00AB);
        look_a(4'd3, 1'b1, '0, 32'h0000_00AB, "R3");
        look_b(4'd6, 1'b0, 3'd4, '0, "R3");
        bcast(3'd4, 32'h1234_5678);
        look_a(4'd6, 1'b1, '0, 32'h1234_5678, "R3");
        look_b(4'd7, 1'b1, '0, 32'h1234_5678, "R3");
        look_a(4'd2, 1'b1, '0, '0, "R3");
    endtask

    task automatic t_supersede();
        rename(4'd5, 3'd1);
        rename(4'd5, 3'd3);
        bcast(3'd1, 32'hDEAD_0001);
        look_a(4'd5, 1'b0, 3'd3, '0, "R5");
        bcast(3'd3, 32'hBEEF_0003);
        look_a(4'd5, 1'b1, '0, 32'hBEEF_0003, "R5");
    endtask

    task automatic t_bypass();
        rename(4'd4, 3'd2);
        bc_valid = 1'b1; bc_tag = 3'd2; bc_value = 32'hCAFE_0002;
        look_b(4'd4, 1'b1, '0, 32'hCAFE_0002, "R6");
        look_a(4'd3, 1'b1, '0, 32'h0000_00AB, "R6");
        tick();
        look_b(4'd4, 1'b1, '0, 32'hCAFE_0002, "R3");
    endtask

    task automatic t_collision();
        rename(4'd8, 3'd6);
        bcast(3'd6, 32'h0000_0808);
        rename(4'd8, 3'd6);
        ren_valid = 1'b1; ren_idx = 4'd8; ren_tag = 3'd7;
        bc_valid = 1'b1; bc_tag = 3'd6; bc_value = 32'h5555_AAAA;
        look_a(4'd8, 1'b1, '0, 32'h5555_AAAA, "R9");
        tick();
        look_a(4'd8, 1'b0, 3'd7, '0, "R7");
        bcast(3'd6, 32'h6666_6666);
        look_a(4'd8, 1'b0, 3'd7, '0, "R7");
        bcast(3'd7, 32'h7777_7777);
        look_a(4'd8, 1'b1, '0, 32'h7777_7777, "R7");
    endtask

    task automatic t_same_cycle_rename_lookup();
        ren_valid = 1'b1; ren_idx = 4'd9; ren_tag = 3'd5;
        look_a(4'd9, 1'b1, '0, '0, "R9");
        tick();
        look_a(4'd9, 1'b0, 3'd5, '0, "R9");
        bcast(3'd5, 32'h0000_0909);
    endtask

    task automatic t_ignored();
        ren_valid = 1'b0; ren_idx = 4'd10; ren_tag = 3'd2;
        tick();
        look_a(4'd10, 1'b1, '0, '0, "R8");
        ren_valid = 1'b1; ren_idx = 4'd10; ren_tag = 3'd0;
        tick();
        look_a(4'd10, 1'b1, '0, '0, "R8");
        rename(4'd11, 3'd1);
        bc_valid = 1'b0; bc_tag = 3'd1; bc_value = 32'hFFFF_0000;
        look_b(4'd11, 1'b0, 3'd1, '0, "R8");
        tick();
        look_b(4'd11, 1'b0, 3'd1, '0, "R8");
        bc_valid = 1'b1; bc_tag = 3'd0; bc_value = 32'hFFFF_1111;
        look_a(4'd10, 1'b1, '0, '0, "R8");
        tick();
        look_a(4'd10, 1'b1, '0, '0, "R8");
        look_b(4'd11, 1'b0, 3'd1, '0, "R8");
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rename_and_write();
        t_supersede();
        t_bypass();
        t_collision();
        t_same_cycle_rename_lookup();
        t_ignored();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        look_a(4'd11, 1'b1, '0, '0, "R1");
        look_b(4'd3, 1'b1, '0, '0, "R1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired before the run ended");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule